// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block is a small word-addressed shared memory that several requesters use at once. Each requester presents an operation code, a word address and a write value. Five operations are available: plain read, plain write, exchange, test-and-set and fetch-and-increment. Every operation reads the addressed word and, when the operation calls for it, writes a new value back. The read and the write happen in the same clock cycle and form one access. No other requester can touch memory between them, so each operation is indivisible.

A round-robin arbiter admits at most one request per cycle. The admitted requester sees its ready signal high in that cycle. One cycle later it receives a response pulse. The response carries the value the word held before the operation.

Software builds locks on top of this. A lock word holds 0 when free and 1 when held. A requester takes the lock by exchanging in a 1, or by test-and-set. Because only one request reaches memory per cycle, two requesters that race for the same free lock are serialized. Exactly one of them reads back 0.

Top module: `amo_unit`

## Requirements
- R1: After reset every memory word reads as 0, and no `req_ready` or `rsp_valid` bit is high.
- R2: A read (op code 0) returns the stored word and leaves it unchanged. Op codes 5, 6 and 7 behave exactly as a read.
- R3: A write (op code 1) stores `wdata` at the address and returns the previous word.
- R4: An exchange (op code 2) stores `wdata` and returns the previous word, in one access.
- R5: A test-and-set (op code 3) stores 1 when the old word is 0. When the old word is nonzero, the word is left unchanged. In both cases it returns the old word.
- R6: A fetch-and-increment (op code 4) returns the old word and stores the old word plus one. A word at its maximum value (all ones) wraps to 0.
- R7: At most one `req_ready` bit is high in any cycle. A `req_ready` bit is high only while the matching `req_valid` bit is high.
- R8: The arbiter grants round-robin. After requester i is granted, the next grant goes to the first requester with `req_valid` high, searching cyclically from i+1.
- R9: `rsp_valid` for requester i is high in exactly the cycle after requester i was granted. In that cycle `rsp_data` carries the word's value from before the operation.
- R10: When two requesters exchange 1 into the same free lock word in the same cycle, one is served first and receives 0. The other is served in a later cycle and receives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_ready | output | NREQ | Request accepted this cycle (grant) |
| req_op | input | NREQ*3 | Op code per requester: 0 read, 1 write, 2 exchange, 3 test-and-set, 4 fetch-and-increment |
| req_addr | input | NREQ*AW | Word address per requester |
| req_wdata | input | NREQ*DW | Write value per requester |
| rsp_valid | output | NREQ | One-cycle response pulse per requester |
| rsp_data | output | DW | Word value from before the granted operation |

## Verification
The assertions check on every cycle that the grant is one-hot or empty and only goes to a valid requester. They also check that each response pulse follows its grant with the pre-operation value, and that write enables agree with the op code: a write always stores, and a test-and-set on a held word never stores. Some behaviour can only be seen in the bench's scenarios. That covers the data each operation leaves in memory, the wrap of fetch-and-increment, the cyclic grant order under sustained contention, and the lock race in which only one requester reads back 0.

// File: rtl/amo_pkg.sv
package amo_pkg;
    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_SWAP  = 3'd2,
        OP_TAS   = 3'd3,
        OP_FINC  = 3'd4
    } amo_op_e;

    function automatic amo_op_e decode_op(input logic [OPW-1:0] bits);
        if (bits > 3'd4) return OP_READ;
        return amo_op_e'(bits);
    endfunction
endpackage

// File: rtl/amo_arbiter.sv
module amo_arbiter #(
    parameter int NREQ = 3,
    localparam int PW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] valid,
    output logic [NREQ-1:0] gnt,
    output logic [PW-1:0]   gidx,
    output logic            any
);
    logic [PW-1:0] ptr;
    int            cand;

    always_comb begin
        gnt  = '0;
        gidx = '0;
        any  = 1'b0;
        cand = 0;
        for (int k = 0; k < NREQ; k++) begin
            cand = (int'(ptr) + k) % NREQ;
            if (!any && valid[cand]) begin
                any       = 1'b1;
                gnt[cand] = 1'b1;
                gidx      = PW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (any) begin
            ptr <= (int'(gidx) == NREQ - 1) ? '0 : PW'(int'(gidx) + 1);
        end
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DW = 8
) (
    input  amo_op_e         op,
    input  logic [DW-1:0]   old_val,
    input  logic [DW-1:0]   wdata,
    output logic            we,
    output logic [DW-1:0]   new_val
);
    always_comb begin
        we      = 1'b0;
        new_val = old_val;
        unique case (op)
            OP_WRITE, OP_SWAP: begin
                we      = 1'b1;
                new_val = wdata;
            end
            OP_TAS: begin
                we      = (old_val == '0);
                new_val = DW'(1);
            end
            OP_FINC: begin
                we      = 1'b1;
                new_val = old_val + DW'(1);
            end
            default: begin
                we      = 1'b0;
                new_val = old_val;
            end
        endcase
    end
endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
    parameter int DW = 8,
    parameter int AW = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rd_data,
    input  logic          we,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] words [DEPTH];

    assign rd_data = words[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[addr] <= wr_data;
        end
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int NREQ = 3,
    parameter int DW   = 8,
    parameter int AW   = 4,
    localparam int PW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NREQ-1:0]    req_valid,
    output logic [NREQ-1:0]    req_ready,
    input  logic [NREQ*3-1:0]  req_op,
    input  logic [NREQ*AW-1:0] req_addr,
    input  logic [NREQ*DW-1:0] req_wdata,
    output logic [NREQ-1:0]    rsp_valid,
    output logic [DW-1:0]      rsp_data
);
    logic [NREQ-1:0] gnt;
    logic [PW-1:0]   gidx;
    logic            g_any;
    amo_op_e         sel_op;
    logic [AW-1:0]   sel_addr;
    logic [DW-1:0]   sel_wdata;
    logic [DW-1:0]   rd_data;
    logic [DW-1:0]   new_val;
    logic            alu_we;
    logic            wr_en;

    amo_arbiter #(.NREQ(NREQ)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .valid (req_valid & {NREQ{~rst}}),
        .gnt   (gnt),
        .gidx  (gidx),
        .any   (g_any)
    );

    assign req_ready = gnt;
    assign sel_op    = decode_op(req_op[int'(gidx)*OPW +: OPW]);
    assign sel_addr  = req_addr[int'(gidx)*AW +: AW];
    assign sel_wdata = req_wdata[int'(gidx)*DW +: DW];

    amo_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .addr    (sel_addr),
        .rd_data (rd_data),
        .we      (wr_en),
        .wr_data (new_val)
    );

    amo_alu #(.DW(DW)) u_alu (
        .op      (sel_op),
        .old_val (rd_data),
        .wdata   (sel_wdata),
        .we      (alu_we),
        .new_val (new_val)
    );

    assign wr_en = g_any & alu_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= gnt;
            if (g_any) rsp_data <= rd_data;
        end
    end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk
    import amo_pkg::*;
#(
    parameter int NREQ = 3,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [NREQ-1:0] req_valid,
    input logic [NREQ-1:0] req_ready,
    input logic [NREQ-1:0] rsp_valid,
    input logic [DW-1:0]   rsp_data,
    input logic            g_any,
    input amo_op_e         g_op,
    input logic [DW-1:0]   old_val,
    input logic            wr_en
);
    a_r7_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready));

    a_r7_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (req_ready & ~req_valid) == '0);

    a_r9_rsp_follows_grant: assert property (@(posedge clk) disable iff (rst)
        req_ready != '0 |=> rsp_valid == $past(req_ready));

    a_r9_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
        req_ready == '0 |=> rsp_valid == '0);

    a_r9_rsp_old_value: assert property (@(posedge clk) disable iff (rst)
        g_any |=> rsp_data == $past(old_val));

    a_r5_tas_held_no_write: assert property (@(posedge clk) disable iff (rst)
        (g_any && g_op == OP_TAS && old_val != '0) |-> !wr_en);

    a_r3_write_stores: assert property (@(posedge clk) disable iff (rst)
        (g_any && g_op == OP_WRITE) |-> wr_en);
endmodule

bind amo_unit amo_unit_chk #(.NREQ(NREQ), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .g_any     (g_any),
    .g_op      (sel_op),
    .old_val   (rd_data),
    .wr_en     (wr_en)
);

// File: tb/amo_unit_test.sv
module amo_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ = 3;
    localparam int DW   = 8;
    localparam int AW   = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NREQ-1:0]    req_valid = '0;
    logic [NREQ-1:0]    req_ready;
    logic [NREQ*3-1:0]  req_op = '0;
    logic [NREQ*AW-1:0] req_addr = '0;
    logic [NREQ*DW-1:0] req_wdata = '0;
    logic [NREQ-1:0]    rsp_valid;
    logic [DW-1:0]      rsp_data;

    int n_run  = 0;
    int n_fail = 0;

    amo_unit #(.NREQ(NREQ), .DW(DW), .AW(AW)) uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_req(input int r, input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] w);
        req_op[r*3 +: 3]     = op;
        req_addr[r*AW +: AW] = a;
        req_wdata[r*DW +: DW] = w;
        req_valid[r]         = 1'b1;
    endtask

    // issue one request from requester r and return the response value
    task automatic do_op(input int r, input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] w, output logic [DW-1:0] old);
        @(negedge clk);
        set_req(r, op, a, w);
        forever begin
            #1;
            if (req_ready[r]) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid[r] = 1'b0;
        chk(rsp_valid == NREQ'(1 << r), "R9", 32'(rsp_valid), 32'(1 << r));
        old = rsp_data;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        @(negedge clk);
        chk(req_ready == '0, "R1", 32'(req_ready), 0);
        chk(rsp_valid == '0, "R1", 32'(rsp_valid), 0);
        do_op(1, 3'd0, 4'd5, 8'h00, v);
        chk(v == 8'h00, "R1", 32'(v), 0);
        do_op(2, 3'd0, 4'd15, 8'h00, v);
        chk(v == 8'h00, "R1", 32'(v), 0);
    endtask

    task automatic t_write_read();
        logic [DW-1:0] v;
        do_op(0, 3'd1, 4'd2, 8'h3C, v);
        chk(v == 8'h00, "R3", 32'(v), 0);
        do_op(1, 3'd1, 4'd2, 8'h5A, v);
        chk(v == 8'h3C, "R3", 32'(v), 32'h3C);
        do_op(2, 3'd0, 4'd2, 8'hFF, v);
        chk(v == 8'h5A, "R2", 32'(v), 32'h5A);
        do_op(0, 3'd7, 4'd2, 8'hFF, v);
        chk(v == 8'h5A, "R2 op7", 32'(v), 32'h5A);
        do_op(1, 3'd5, 4'd2, 8'h01, v);
        chk(v == 8'h5A, "R2 op5", 32'(v), 32'h5A);
        do_op(1, 3'd0, 4'd2, 8'h00, v);
        chk(v == 8'h5A, "R2 unchanged", 32'(v), 32'h5A);
    endtask

    task automatic t_swap();
        logic [DW-1:0] v;
        do_op(2, 3'd2, 4'd2, 8'h11, v);
        chk(v == 8'h5A, "R4", 32'(v), 32'h5A);
        do_op(0, 3'd0, 4'd2, 8'h00, v);
        chk(v == 8'h11, "R4", 32'(v), 32'h11);
    endtask

    task automatic t_tas();
        logic [DW-1:0] v;
        do_op(0, 3'd3, 4'd3, 8'h00, v);
        chk(v == 8'h00, "R5 free", 32'(v), 0);
        do_op(1, 3'd0, 4'd3, 8'h00, v);
        chk(v == 8'h01, "R5 set", 32'(v), 1);
        do_op(2, 3'd3, 4'd3, 8'h00, v);
        chk(v == 8'h01, "R5 held", 32'(v), 1);
        do_op(1, 3'd3, 4'd2, 8'h00, v);
        chk(v == 8'h11, "R5 nonzero", 32'(v), 32'h11);
        do_op(0, 3'd0, 4'd2, 8'h00, v);
        chk(v == 8'h11, "R5 unchanged", 32'(v), 32'h11);
    endtask

    task automatic t_finc();
        logic [DW-1:0] v;
        do_op(0, 3'd1, 4'd4, 8'hFE, v);
        do_op(1, 3'd4, 4'd4, 8'h00, v);
        chk(v == 8'hFE, "R6", 32'(v), 32'hFE);
        do_op(2, 3'd4, 4'd4, 8'h00, v);
        chk(v == 8'hFF, "R6", 32'(v), 32'hFF);
        do_op(0, 3'd0, 4'd4, 8'h00, v);
        chk(v == 8'h00, "R6 wrap", 32'(v), 0);
    endtask

    task automatic t_lock_race();
        int w;
        int l;
        w = 0;
        l = 0;
        @(negedge clk);
        set_req(0, 3'd2, 4'd6, 8'h01);
        set_req(1, 3'd2, 4'd6, 8'h01);
        #1;
        chk($countones(req_ready) == 1, "R7", 32'(req_ready), 1);
        w = req_ready[0] ? 0 : 1;
        l = 1 - w;
        @(negedge clk);
        req_valid[w] = 1'b0;
        chk(rsp_valid == NREQ'(1 << w), "R9", 32'(rsp_valid), 32'(1 << w));
        chk(rsp_data == 8'h00, "R10 first", 32'(rsp_data), 0);
        #1;
        chk(req_ready == NREQ'(1 << l), "R8", 32'(req_ready), 32'(1 << l));
        @(negedge clk);
        req_valid[l] = 1'b0;
        chk(rsp_valid == NREQ'(1 << l), "R9", 32'(rsp_valid), 32'(1 << l));
        chk(rsp_data == 8'h01, "R10 second", 32'(rsp_data), 1);
    endtask

    task automatic t_rotate();
        int prev;
        int cur;
        prev = -1;
        @(negedge clk);
        for (int r = 0; r < NREQ; r++) set_req(r, 3'd0, 4'd1, 8'h00);
        for (int c = 0; c < 5; c++) begin
            #1;
            cur = -1;
            for (int r = 0; r < NREQ; r++) if (req_ready[r]) cur = r;
            chk($countones(req_ready) == 1, "R7", 32'(req_ready), 1);
            if (prev >= 0)
                chk(cur == (prev + 1) % NREQ, "R8", 32'(cur), 32'((prev + 1) % NREQ));
            @(negedge clk);
            if (cur >= 0)
                chk(rsp_valid == NREQ'(1 << cur), "R9", 32'(rsp_valid), 32'(1 << cur));
            prev = cur;
        end
        req_valid = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_read();
        t_swap();
        t_tas();
        t_finc();
        t_lock_race();
        t_rotate();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule